// File: doc/BRIEF.md
# Oscillator Trim and Clock-Out Control

This block stores the trim code that tunes an on-chip RC oscillator and decides what the shared clock/IO pin puts out. Software loads the trim through a simple write strobe with an 8-bit data word. Only the upper six bits are kept. The stored code is presented continuously on a 6-bit output for the oscillator model. On a read the code appears in the upper six bits, and the two low bits are always zero. At reset the register holds a mid-scale value until software loads the factory calibration value. That value nominally sets the oscillator near 4 MHz at 5 V and room temperature.

A 3-bit oscillator-mode configuration field controls the pin. Two of its codes select an RC oscillator together with clock output: 3'b101 for the internal RC and 3'b111 for the external RC. In those two modes the pin is driven with the system clock divided by four, at 50 % duty. Under any of the other six codes, the pin value and its output-enable come from the general I/O path. The divider runs freely from reset, so its phase never depends on the mode.

Top module: `osctrim_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, rd_data is 8'h80, trim_code is 6'h20, pin_o is 0 and pin_oe is 0.
- R2: rd_data[7:2] always equals trim_code, and rd_data[1:0] reads 2'b00 whatever value was written to those bits.
- R3: When wr_en is high at a rising edge, trim_code takes wr_data[7:2] at that edge. Before the edge the old value is still visible.
- R4: When wr_en is low, the stored trim does not change, whatever wr_data carries.
- R5: When mode_cfg is 3'b101 or 3'b111 at a rising edge, pin_oe is 1 after that edge and pin_o carries the divided clock.
- R6: For mode_cfg values other than 3'b101 and 3'b111, pin_o and pin_oe after a rising edge equal gpio_o and gpio_oe as they were sampled at that edge.
- R7: The divided clock has a period of four clocks and 50 % duty. Number the edges from 1, starting at the first rising edge with reset low. In a clock-out mode, pin_o is 1 after edge k exactly when k mod 4 is 3 or 0.
- R8: The divider keeps counting while the pin is in general I/O mode. Changing into a clock-out mode therefore keeps the phase given in R7, and a new reset restarts that numbering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the trim register |
| wr_data | input | 8 | Write data; bits 7:2 are stored |
| rd_data | output | 8 | Trim readback, low two bits zero |
| trim_code | output | 6 | Stored trim code for the oscillator |
| mode_cfg | input | 3 | Oscillator-mode configuration field |
| gpio_o | input | 1 | Pin value from the general I/O path |
| gpio_oe | input | 1 | Pin output-enable from the general I/O path |
| pin_o | output | 1 | Registered pin output value |
| pin_oe | output | 1 | Registered pin output-enable |

## Verification
A trim write is due one rising edge after its strobe. The bench checks the old value on the falling edge before that rising edge and the new value on the falling edge after it. Both pin outputs pass through one register stage, so a change in the general I/O inputs or in the mode field shows up after the next rising edge. The divided clock leaves the divider one edge later still. The bench counts rising edges from reset release and samples every output on the falling edge. It compares pin_o against the edge-number rule of R7 rather than timing against earlier samples.

// File: rtl/osctrim_pkg.sv
package osctrim_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    OSC_LP        = 3'b000,
    OSC_XT        = 3'b001,
    OSC_HS        = 3'b010,
    OSC_EXTCLK    = 3'b011,
    OSC_INTRC_IO  = 3'b100,
    OSC_INTRC_CLK = 3'b101,
    OSC_EXTRC_IO  = 3'b110,
    OSC_EXTRC_CLK = 3'b111
  } osc_mode_e;

  function automatic logic mode_drives_clk(input logic [MODE_W-1:0] m);
    return (m == OSC_INTRC_CLK) || (m == OSC_EXTRC_CLK);
  endfunction

  typedef struct packed {
    logic val;
    logic oe;
  } pin_drv_t;

endpackage

// File: rtl/osctrim_reg.sv
module osctrim_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TRIM_LSB = 2,
  parameter logic [DATA_W-1:0] RST_VAL = 8'h80
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DATA_W-TRIM_LSB-1:0] code
);
  localparam int unsigned TRIM_W = DATA_W - TRIM_LSB;
  localparam logic [TRIM_W-1:0] RST_CODE = RST_VAL[DATA_W-1:TRIM_LSB];

  logic [TRIM_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RST_CODE;
    end else if (wr_en) begin
      code_q <= wr_data[DATA_W-1:TRIM_LSB];
    end
  end

  generate
    if (TRIM_LSB == 0) begin : g_full
      assign rd_data = code_q;
    end else begin : g_pad
      assign rd_data = {code_q, {TRIM_LSB{1'b0}}};
    end
  endgenerate

  assign code = code_q;
endmodule

// File: rtl/osctrim_clkdiv.sv
module osctrim_clkdiv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic div_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV / 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             div_q;

  always_comb begin
    if (cnt_q == LAST) cnt_nxt = '0;
    else               cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt >= HALF);
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/osctrim_pinmux.sv
module osctrim_pinmux
  import osctrim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              div_clk,
  input  logic              gpio_o,
  input  logic              gpio_oe,
  output logic              pin_o,
  output logic              pin_oe
);
  pin_drv_t sel_d;
  pin_drv_t drv_q;

  always_comb begin
    if (mode_drives_clk(mode)) begin
      sel_d.val = div_clk;
      sel_d.oe  = 1'b1;
    end else begin
      sel_d.val = gpio_o;
      sel_d.oe  = gpio_oe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= '0;
    else     drv_q <= sel_d;
  end

  assign pin_o  = drv_q.val;
  assign pin_oe = drv_q.oe;
endmodule

// File: rtl/osctrim_ctrl.sv
module osctrim_ctrl
  import osctrim_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TRIM_LSB = 2,
  parameter logic [DATA_W-1:0] RST_VAL = 8'h80,
  parameter int unsigned CLK_DIV  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DATA_W-TRIM_LSB-1:0] trim_code,
  input  logic [MODE_W-1:0]          mode_cfg,
  input  logic                       gpio_o,
  input  logic                       gpio_oe,
  output logic                       pin_o,
  output logic                       pin_oe
);
  logic div_clk;

  osctrim_reg #(
    .DATA_W  (DATA_W),
    .TRIM_LSB(TRIM_LSB),
    .RST_VAL (RST_VAL)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .code   (trim_code)
  );

  osctrim_clkdiv #(
    .DIV(CLK_DIV)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .div_o(div_clk)
  );

  osctrim_pinmux u_mux (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_cfg),
    .div_clk(div_clk),
    .gpio_o (gpio_o),
    .gpio_oe(gpio_oe),
    .pin_o  (pin_o),
    .pin_oe (pin_oe)
  );
endmodule

// File: rtl/osctrim_ctrl_chk.sv
module osctrim_ctrl_chk
  import osctrim_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TRIM_LSB = 2,
  parameter logic [DATA_W-1:0] RST_VAL = 8'h80
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [DATA_W-1:0]          wr_data,
  input logic [DATA_W-1:0]          rd_data,
  input logic [MODE_W-1:0]          mode_cfg,
  input logic                       gpio_o,
  input logic                       gpio_oe,
  input logic                       pin_o,
  input logic                       pin_oe
);
  logic clk_mode;
  assign clk_mode = (mode_cfg == 3'b101) || (mode_cfg == 3'b111);

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == RST_VAL && !pin_o && !pin_oe));

  // R3 and R2
  a_r3_write_capture: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[DATA_W-1:TRIM_LSB] == $past(wr_data[DATA_W-1:TRIM_LSB])
               && rd_data[TRIM_LSB-1:0] == '0));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));

  // R5
  a_r5_clk_oe: assert property (@(posedge clk) disable iff (rst)
    clk_mode |=> pin_oe);

  // R6
  a_r6_gpio_follow: assert property (@(posedge clk) disable iff (rst)
    !clk_mode |=> (pin_o == $past(gpio_o) && pin_oe == $past(gpio_oe)));
endmodule

bind osctrim_ctrl osctrim_ctrl_chk #(
  .DATA_W  (DATA_W),
  .TRIM_LSB(TRIM_LSB),
  .RST_VAL (RST_VAL)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .mode_cfg(mode_cfg),
  .gpio_o  (gpio_o),
  .gpio_oe (gpio_oe),
  .pin_o   (pin_o),
  .pin_oe  (pin_oe)
);

// File: tb/osctrim_ctrl_tb_top.sv
`timescale 1ns/1ps
module osctrim_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [5:0] trim_code;
  logic [2:0] mode_cfg = 3'b000;
  logic       gpio_o = 1'b0;
  logic       gpio_oe = 1'b0;
  logic       pin_o;
  logic       pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  int edge_k = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edge_k = 0;
    else     edge_k = edge_k + 1;
  end

  osctrim_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trim_code(trim_code), .mode_cfg(mode_cfg),
    .gpio_o(gpio_o), .gpio_oe(gpio_oe), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // {wr_en, wr_data, expected rd_data}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'hFF, 8'hFC},
    {1'b1, 8'h03, 8'h00},
    {1'b0, 8'hF0, 8'h00},
    {1'b1, 8'hA5, 8'hA4},
    {1'b0, 8'h00, 8'hA4},
    {1'b1, 8'h5A, 8'h58},
    {1'b1, 8'h82, 8'h80},
    {1'b1, 8'h7E, 8'h7C}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit clk_exp(input int k);
    return (k % 4 == 3) || (k % 4 == 0);
  endfunction

  task automatic check_clk_cycles(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(pin_o == clk_exp(edge_k), req, pin_o, clk_exp(edge_k));
      chk(pin_oe == 1'b1, "R5 oe", pin_oe, 1);
      highs += pin_o;
    end
    chk(highs == n / 2, "R7 duty", highs, n / 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state during reset
    chk(rd_data == 8'h80, "R1 rd", rd_data, 8'h80);
    chk(trim_code == 6'h20, "R1 code", trim_code, 6'h20);
    chk(!pin_o && !pin_oe, "R1 pin", {pin_o, pin_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 8'h80 && !pin_oe, "R1 after release", rd_data, 8'h80);

    // Trim vectors: R2, R3, R4
    for (int v = 0; v < 8; v++) begin
      logic [7:0] prev;
      prev = rd_data;
      wr_en   = VEC[v][16];
      wr_data = VEC[v][15:8];
      #0.5;
      chk(rd_data == prev, "R3 not before edge", rd_data, prev);
      @(negedge clk);
      chk(rd_data == VEC[v][7:0], VEC[v][16] ? "R3 write" : "R4 hold", rd_data, VEC[v][7:0]);
      chk(rd_data[1:0] == 2'b00, "R2 low bits", rd_data[1:0], 0);
      chk(trim_code == VEC[v][7:2], "R2 code", trim_code, VEC[v][7:2]);
    end
    wr_en = 1'b0;

    // Mode sweep: R5, R6, R7, R8
    for (int m = 0; m < 8; m++) begin
      mode_cfg = 3'(m);
      if (m == 5 || m == 7) begin
        check_clk_cycles(8, m == 5 ? "R8 phase after gpio" : "R7 clk");
      end else begin
        for (int i = 0; i < 6; i++) begin
          logic go, goe;
          go  = 1'(i ^ m);
          goe = 1'((i >> 1) ^ m);
          gpio_o = go;
          gpio_oe = goe;
          @(negedge clk);
          chk(pin_o == go && pin_oe == goe, "R6 gpio", {pin_o, pin_oe}, {go, goe});
        end
      end
    end

    // R4: data toggles with no strobe in clock mode
    wr_data = 8'h11;
    @(negedge clk);
    chk(rd_data == 8'h7C, "R4 no strobe", rd_data, 8'h7C);

    // R8: reset mid-run restarts numbering; R1 restores trim
    mode_cfg = 3'b111;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_data == 8'h80 && !pin_o && !pin_oe, "R1 rerun", rd_data, 8'h80);
    rst = 1'b0;
    check_clk_cycles(12, "R8 restart");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule